// File: doc/BRIEF.md
# Boot-Block Flash Command Sequencer with Erase Suspend

This block decodes the command writes that a host sends to a parallel NOR-style boot-block flash and sequences the resulting operations. A bus write carries a command byte in the low eight bits of the data word, together with an address. The block keeps track of the selected read mode (array, status or identifier). It runs two-write program and erase sequences and measures each operation with a count-based timer that stands in for the real algorithm. It also maintains a status byte.

An erase that is running can be suspended. While the block waits for the suspend to take effect, and again once it is suspended, a narrower set of commands is accepted. Array reads are possible while suspended, and a confirm write resumes the erase with the time that was left. An active-low reset/power-down input clears everything at once, without waiting for a clock. The memory array, the high-voltage control and the real algorithms are not part of this block.

Top module: `flash_cmd_seq`

## Requirements
- R1: While `pd_n` is low, and immediately on its falling edge with no clock needed, the outputs are `rd_mode`=0 (array), `busy`=0, `suspended`=0, `prog_done`=0, `erase_done`=0 and `status`=8'h80. Any program, erase or suspend is abandoned.
- R2: When idle, code FFh selects array reads (`rd_mode`=0), 70h selects status reads (`rd_mode`=1) and 90h selects identifier reads (`rd_mode`=2). Codes with no defined meaning leave `rd_mode` and `status` unchanged.
- R3: The write of 40h followed by any second write starts a program. The second write's address and data appear on `op_addr`/`op_data`. `busy` is high for exactly PROG_CYC sampled cycles, and then `prog_done` pulses for one cycle. After this, `rd_mode` is 1.
- R4: The write of 20h followed by D0h starts an erase and captures the D0h write's address and data. With no suspend, `busy` is high for exactly ERASE_CYC cycles, and then `erase_done` pulses for one cycle, with `rd_mode` at 1.
- R5: The write of 20h followed by any code other than D0h starts no erase. It sets status bits 5 (erase error) and 4 (sequence error), giving `status`=8'hB0, and sets `rd_mode` to 1. When the block is idle, 50h clears bits 5 and 4 and leaves `rd_mode` unchanged.
- R6: While `busy` is high, `rd_mode` reads 1 and status bit 7 reads 0. Writes other than 70h and B0h during an erase, and all writes during a program, leave `op_addr`, `op_data` and the operation length unchanged.
- R7: B0h is honoured only during an erase. When idle or during a program it has no effect on `rd_mode`, `status`, `suspended` or the program length.
- R8: After a B0h write is accepted during an erase, `suspended` (status bit 6) rises after exactly SUSP_LAT cycles, and `busy` then drops. The erase timer does not advance from the accepted B0h onward.
- R9: While suspended, only FFh, 70h and D0h act. FFh gives `rd_mode`=0 and 70h gives `rd_mode`=1. D0h clears `suspended`, raises `busy` and finishes the erase, so that the total number of busy cycles is ERASE_CYC+SUSP_LAT. The codes 20h, 40h, 50h and 90h are ignored.
- R10: D0h has no effect when idle. D0h written while a suspend is pending cancels the suspend, and the erase continues without `suspended` ever rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pd_n | input | 1 | Asynchronous active-low reset/power-down |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data; command code in bits 7:0 |
| rd_mode | output | 2 | Effective read source: 0 array, 1 status, 2 identifier |
| busy | output | 1 | Operation executing or suspend pending |
| suspended | output | 1 | Erase is held in suspend |
| prog_done | output | 1 | One-cycle pulse at program completion |
| erase_done | output | 1 | One-cycle pulse at erase completion |
| op_addr | output | AW | Address captured at operation start |
| op_data | output | DW | Data captured at operation start |
| status | output | 8 | {ready, suspended, erase error, sequence error, 4'b0} |

## Verification
The hardest states to reach are the short pending window between an accepted suspend and the suspended state, and the resumed erase whose remaining length depends on how far it ran before the suspend. The stimulus first sets both error bits through an aborted erase setup. It then starts an erase, suspends it part way, and sends every code that must be ignored while suspended. It resumes and counts the busy cycles against ERASE_CYC plus SUSP_LAT. A second run writes D0h one cycle into the pending window. Random idle command streams and random programs, some with stray B0h and command writes during the busy time, are checked against bench models of the read mode and the status byte.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_IDENT  = 2'd2
  } rmode_e;

  typedef enum logic [3:0] {
    CMD_NONE, CMD_RD_ARRAY, CMD_RD_STAT, CMD_RD_ID, CMD_CLR_STAT,
    CMD_ERS_SETUP, CMD_PRG_SETUP, CMD_CONFIRM, CMD_SUSPEND
  } cmd_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ERS_ARM, PH_PRG_ARM, PH_PROGRAM,
    PH_ERASE, PH_SUSP_WAIT, PH_SUSPENDED
  } phase_e;

  function automatic cmd_e decode_cmd(input logic [7:0] code);
    case (code)
      8'hFF:   return CMD_RD_ARRAY;
      8'h70:   return CMD_RD_STAT;
      8'h90:   return CMD_RD_ID;
      8'h50:   return CMD_CLR_STAT;
      8'h20:   return CMD_ERS_SETUP;
      8'h40:   return CMD_PRG_SETUP;
      8'hD0:   return CMD_CONFIRM;
      8'hB0:   return CMD_SUSPEND;
      default: return CMD_NONE;
    endcase
  endfunction

  function automatic logic [7:0] pack_status(input logic ready, input logic susp,
                                             input logic ers_err, input logic seq_err);
    return {ready, susp, ers_err, seq_err, 4'b0000};
  endfunction

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output cmd_e          cmd
);
  always_comb cmd = wr_en ? decode_cmd(wr_data[7:0]) : CMD_NONE;
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         pd_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         last
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge pd_n) begin
    if (!pd_n)                        cnt_q <= '0;
    else if (load)                    cnt_q <= load_val;
    else if (run && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign last = run && (cnt_q == W'(1));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int AW        = 18,
  parameter int DW        = 16,
  parameter int PROG_CYC  = 12,
  parameter int ERASE_CYC = 40,
  parameter int SUSP_LAT  = 3
) (
  input  logic          clk,
  input  logic          pd_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [1:0]    rd_mode,
  output logic          busy,
  output logic          suspended,
  output logic          prog_done,
  output logic          erase_done,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic [7:0]    status
);
  localparam int OP_MAX = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int OPW    = $clog2(OP_MAX + 1);
  localparam int SUW    = $clog2(SUSP_LAT + 1);

  phase_e phase_q, phase_n;
  rmode_e mode_q, mode_n;
  logic   ers_err_q, ers_err_n, seq_err_q, seq_err_n, susp_q, susp_n;
  logic   pdone_n, edone_n;
  logic   ld_op, ld_prog, ld_sus, latch;
  logic   op_last, sus_last;
  cmd_e   cmd;

  // named internal events for the checker
  logic   ev_susp_req, ev_resume, ev_seq_abort;

  flash_cmd_decode #(.DW(DW)) u_dec (.wr_en(wr_en), .wr_data(wr_data), .cmd(cmd));

  flash_op_timer #(.W(OPW)) u_op_tmr (
    .clk(clk), .pd_n(pd_n), .load(ld_op),
    .load_val(ld_prog ? OPW'(PROG_CYC) : OPW'(ERASE_CYC)),
    .run(phase_q == PH_PROGRAM || phase_q == PH_ERASE), .last(op_last));

  flash_op_timer #(.W(SUW)) u_sus_tmr (
    .clk(clk), .pd_n(pd_n), .load(ld_sus), .load_val(SUW'(SUSP_LAT)),
    .run(phase_q == PH_SUSP_WAIT), .last(sus_last));

  always_comb begin
    phase_n = phase_q;   mode_n = mode_q;
    ers_err_n = ers_err_q; seq_err_n = seq_err_q; susp_n = susp_q;
    pdone_n = 1'b0; edone_n = 1'b0;
    ld_op = 1'b0; ld_prog = 1'b0; ld_sus = 1'b0; latch = 1'b0;
    ev_susp_req = 1'b0; ev_resume = 1'b0; ev_seq_abort = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        case (cmd)
          CMD_RD_ARRAY:  mode_n = RM_ARRAY;
          CMD_RD_STAT:   mode_n = RM_STATUS;
          CMD_RD_ID:     mode_n = RM_IDENT;
          CMD_CLR_STAT:  begin ers_err_n = 1'b0; seq_err_n = 1'b0; end
          CMD_ERS_SETUP: begin phase_n = PH_ERS_ARM; mode_n = RM_STATUS; end
          CMD_PRG_SETUP: begin phase_n = PH_PRG_ARM; mode_n = RM_STATUS; end
          default: ;
        endcase
      end
      PH_ERS_ARM: if (wr_en) begin
        if (cmd == CMD_CONFIRM) begin
          phase_n = PH_ERASE; ld_op = 1'b1; latch = 1'b1;
        end else begin
          phase_n = PH_IDLE; mode_n = RM_STATUS;
          ers_err_n = 1'b1; seq_err_n = 1'b1; ev_seq_abort = 1'b1;
        end
      end
      PH_PRG_ARM: if (wr_en) begin
        phase_n = PH_PROGRAM; ld_op = 1'b1; ld_prog = 1'b1; latch = 1'b1;
      end
      PH_PROGRAM: if (op_last) begin
        phase_n = PH_IDLE; pdone_n = 1'b1;
      end
      PH_ERASE: begin
        if (op_last) begin
          phase_n = PH_IDLE; edone_n = 1'b1;
        end else if (cmd == CMD_SUSPEND) begin
          phase_n = PH_SUSP_WAIT; ld_sus = 1'b1; ev_susp_req = 1'b1;
        end else if (cmd == CMD_RD_STAT) begin
          mode_n = RM_STATUS;
        end
      end
      PH_SUSP_WAIT: begin
        if (cmd == CMD_CONFIRM) begin
          phase_n = PH_ERASE; ev_resume = 1'b1;
        end else if (sus_last) begin
          phase_n = PH_SUSPENDED; susp_n = 1'b1;
        end else if (cmd == CMD_RD_STAT) begin
          mode_n = RM_STATUS;
        end
      end
      PH_SUSPENDED: begin
        case (cmd)
          CMD_RD_ARRAY: mode_n = RM_ARRAY;
          CMD_RD_STAT:  mode_n = RM_STATUS;
          CMD_CONFIRM: begin
            phase_n = PH_ERASE; susp_n = 1'b0; mode_n = RM_STATUS; ev_resume = 1'b1;
          end
          default: ;
        endcase
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge pd_n) begin
    if (!pd_n) begin
      phase_q <= PH_IDLE;  mode_q <= RM_ARRAY;
      ers_err_q <= 1'b0;   seq_err_q <= 1'b0; susp_q <= 1'b0;
      prog_done <= 1'b0;   erase_done <= 1'b0;
      op_addr <= '0;       op_data <= '0;
    end else begin
      phase_q <= phase_n;  mode_q <= mode_n;
      ers_err_q <= ers_err_n; seq_err_q <= seq_err_n; susp_q <= susp_n;
      prog_done <= pdone_n; erase_done <= edone_n;
      if (latch) begin
        op_addr <= wr_addr;
        op_data <= wr_data;
      end
    end
  end

  assign busy      = (phase_q == PH_PROGRAM) || (phase_q == PH_ERASE) ||
                     (phase_q == PH_SUSP_WAIT);
  assign suspended = susp_q;
  assign rd_mode   = busy ? RM_STATUS : mode_q;
  assign status    = pack_status(!busy, susp_q, ers_err_q, seq_err_q);
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int AW = 18
) (
  input logic          clk,
  input logic          pd_n,
  input logic          wr_en,
  input logic          busy,
  input logic          suspended,
  input logic          prog_done,
  input logic          erase_done,
  input logic [AW-1:0] op_addr,
  input logic [7:0]    status,
  input logic          ev_susp_req,
  input logic          ev_resume
);
  assert_prog_after_busy_R3: assert property (@(posedge clk) disable iff (!pd_n)
    prog_done |-> $past(busy));

  assert_erase_pulse_R4: assert property (@(posedge clk) disable iff (!pd_n)
    erase_done |=> !erase_done);

  assert_seqerr_by_write_R5: assert property (@(posedge clk) disable iff (!pd_n)
    $rose(status[4]) |-> $past(wr_en));

  assert_addr_frozen_R6: assert property (@(posedge clk) disable iff (!pd_n)
    (busy && $past(busy)) |-> $stable(op_addr));

  assert_susp_req_R7: assert property (@(posedge clk) disable iff (!pd_n)
    ev_susp_req |=> (busy && !suspended));

  assert_susp_enter_R8: assert property (@(posedge clk) disable iff (!pd_n)
    $rose(suspended) |-> (!busy && $past(busy)));

  assert_resume_R9: assert property (@(posedge clk) disable iff (!pd_n)
    ev_resume |=> (busy && !suspended));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .pd_n(pd_n), .wr_en(wr_en), .busy(busy), .suspended(suspended),
  .prog_done(prog_done), .erase_done(erase_done), .op_addr(op_addr),
  .status(status), .ev_susp_req(ev_susp_req), .ev_resume(ev_resume));

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18, DW = 16, PROG_CYC = 12, ERASE_CYC = 40, SUSP_LAT = 3;

  logic          clk = 1'b0, pd_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    rd_mode;
  logic          busy, suspended, prog_done, erase_done;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic [7:0]    status;

  int n_chk = 0, n_bad = 0, bc = 0;
  logic seen_susp;
  logic [1:0] m_mode;
  logic m_ee, m_se;

  flash_cmd_seq #(.AW(AW), .DW(DW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
                  .SUSP_LAT(SUSP_LAT)) u_dut (
    .clk(clk), .pd_n(pd_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_mode(rd_mode), .busy(busy), .suspended(suspended), .prog_done(prog_done),
    .erase_done(erase_done), .op_addr(op_addr), .op_data(op_data), .status(status));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] exp_sts(input logic rdy, input logic sp,
                                         input logic ee, input logic se);
    logic [7:0] v;
    v = 8'h00;
    if (rdy) v = v + 8'h80;
    if (sp)  v = v + 8'h40;
    if (ee)  v = v + 8'h20;
    if (se)  v = v + 8'h10;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (busy) bc++;
    if (suspended) seen_susp = 1'b1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic wait_done(input bit for_erase);
    int g;
    g = 0;
    while (!(for_erase ? erase_done : prog_done) && g < 2000) begin step(); g++; end
    if (g >= 2000) chk("watchdog", 1, 0);
  endtask

  task automatic pulse_pd();
    #1 pd_n = 1'b0;
    #1;
    chk("R1 mode", rd_mode, 0);   chk("R1 busy", busy, 0);
    chk("R1 susp", suspended, 0); chk("R1 status", status, 8'h80);
    chk("R1 done", {prog_done, erase_done}, 0);
    step();
    pd_n = 1'b1;
    step();
    m_mode = 0; m_ee = 0; m_se = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [7:0] c;
    void'($urandom(32'h5EED_0042));
    seen_susp = 1'b0;
    m_mode = 0; m_ee = 0; m_se = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset mode", rd_mode, 0);
    chk("R1 reset status", status, 8'h80);
    pd_n = 1'b1;
    step();

    // R2 / R7 / R10: random idle command stream
    for (int i = 0; i < 300; i++) begin
      c = 8'($urandom);
      case ($urandom % 6)
        0: c = 8'hFF; 1: c = 8'h70; 2: c = 8'h90; 3: c = 8'hB0; 4: c = 8'hD0;
        default: ;
      endcase
      if (c == 8'h20 || c == 8'h40) c = 8'h00;
      wr(AW'($urandom), DW'({8'($urandom), c}));
      if (c == 8'hFF) m_mode = 0;
      else if (c == 8'h70) m_mode = 1;
      else if (c == 8'h90) m_mode = 2;
      chk("R2 idle mode", rd_mode, m_mode);
      chk("R7 R10 idle status", status, 8'h80);
      chk("R10 idle busy", busy, 0);
    end

    // R3 / R6 / R7: random programs with stray writes while busy
    for (int i = 0; i < 25; i++) begin
      a = AW'($urandom); d = DW'($urandom);
      wr(AW'($urandom), 16'h0040);
      chk("R3 setup mode", rd_mode, 1);
      bc = 0;
      wr(a, d);
      for (int k = 0; k < 4; k++) begin
        wr(AW'($urandom), (k == 0) ? 16'h00B0 : DW'($urandom));
        chk("R6 busy mode", rd_mode, 1);
        chk("R6 busy status", status[7], 0);
      end
      wait_done(1'b0);
      chk("R3 R7 prog length", bc, PROG_CYC);
      chk("R3 R6 op_addr", op_addr, a);
      chk("R3 R6 op_data", op_data, d);
      chk("R3 mode after", rd_mode, 1);
      chk("R7 no suspend", suspended, 0);
      step();
      chk("R3 done pulse", prog_done, 0);
    end

    // R5: aborted erase setup, then clear
    wr('0, 16'h0020);
    wr('0, 16'h00FF);
    chk("R5 abort mode", rd_mode, 1);
    chk("R5 abort status", status, 8'hB0);
    chk("R5 no busy", busy, 0);
    wr('0, 16'h0090);
    wr('0, 16'h0050);
    chk("R5 clear status", status, 8'h80);
    chk("R5 clear keeps mode", rd_mode, 2);

    // R4: plain erase with ignored writes
    wr(18'h00123, 16'h0020);
    bc = 0;
    wr(18'h01AB5, 16'h11D0);
    wr(18'h3FFFF, 16'h00FF);
    wr(18'h00001, 16'h0040);
    chk("R6 erase mode", rd_mode, 1);
    wait_done(1'b1);
    chk("R4 erase length", bc, ERASE_CYC);
    chk("R4 R6 op_addr", op_addr, 18'h01AB5);
    chk("R4 op_data", op_data, 16'h11D0);
    chk("R4 mode after", rd_mode, 1);
    step();
    chk("R4 done pulse", erase_done, 0);

    // R8 / R9: suspend, ignored codes, resume (error bits preset)
    wr('0, 16'h0020); wr('0, 16'h0000);
    chk("R5 preset", status, 8'hB0);
    wr('0, 16'h0020);
    bc = 0;
    wr(18'h00777, 16'h00D0);
    repeat (3) step();
    wr('0, 16'h00B0);
    repeat (SUSP_LAT - 1) step();
    chk("R8 not yet", suspended, 0);
    chk("R8 still busy", busy, 1);
    step();
    chk("R8 suspended", suspended, 1);
    chk("R8 idle", busy, 0);
    chk("R8 status", status, 8'hF0);
    repeat (5) step();
    chk("R8 no finish", erase_done, 0);
    wr('0, 16'h00FF);
    chk("R9 array", rd_mode, 0);
    wr('0, 16'h0090);
    chk("R9 ident ignored", rd_mode, 0);
    wr('0, 16'h0020);
    chk("R9 setup ignored", rd_mode, 0);
    wr('0, 16'h0070);
    chk("R9 status mode", rd_mode, 1);
    wr('0, 16'h0050);
    chk("R9 clear ignored", status, 8'hF0);
    wr('0, 16'h0040);
    wr('0, 16'h00FF);
    chk("R9 program ignored", rd_mode, 0);
    chk("R9 no busy", busy, 0);
    wr('0, 16'h00D0);
    chk("R9 resumed", {busy, suspended}, 2'b10);
    wait_done(1'b1);
    chk("R9 total busy", bc, ERASE_CYC + SUSP_LAT);
    chk("R9 op_addr", op_addr, 18'h00777);

    // R10: resume during pending suspend cancels it
    wr('0, 16'h0050);
    wr('0, 16'h0020);
    bc = 0; seen_susp = 1'b0;
    wr('0, 16'h00D0);
    repeat (5) step();
    wr('0, 16'h00B0);
    wr('0, 16'h00D0);
    wait_done(1'b1);
    chk("R10 cancel length", bc, ERASE_CYC + 1);
    chk("R10 never suspended", seen_susp, 0);

    // R1: power-down while suspended and while programming
    wr('0, 16'h0020); wr('0, 16'h00D0);
    wr('0, 16'h00B0);
    repeat (SUSP_LAT + 1) step();
    chk("R1 pre suspended", suspended, 1);
    pulse_pd();
    chk("R1 after pd", status, 8'h80);
    wr('0, 16'h0040); wr(18'h5, 16'h5);
    repeat (3) step();
    pulse_pd();
    repeat (PROG_CYC + 2) step();
    chk("R1 abort no done", prog_done, 0);
    chk("R1 abort idle", busy, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule